// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block gathers thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents a single request to the processor. The request is a 3-bit interrupt level and an 8-bit vector number. Every clock, each source's level is copied into a pending register. Pending bits that are not blocked by the mask register form the active set. Each source has an 8-bit control register. Its low five bits are a combined level-and-priority code, and the active source with the largest code wins.

The winner's control register also chooses how the vector is formed. In autovector mode the vector is computed from the level. Otherwise the vector is read from a programmable vector register: one for the watchdog source and one each for the two serial-port sources. Software programs the block through a byte-wide register port with a combinational read path. The level and vector outputs are registered.

Top module: `prio_vec_intc`

## Requirements
- R1: The active set is pending AND NOT mask, so a mask bit of 1 blocks its source. After reset, the mask holds 1 for every source. Its 16-bit image 0x3FFE reads as 0x3F at byte 0x36 and 0xFE at byte 0x37, with source n at image bit n.
- R2: Among active sources, the winner is the one with the largest control bits [4:0]. On equal values, the lowest-numbered source wins.
- R3: When no source is active, or when the winning code in bits [4:0] is below 4, both the level output and the vector output are 0.
- R4: The level output equals control bits [4:2] of the winner.
- R5: When the winner has control bit 7 set, the vector output is 24 plus the level.
- R6: When the winner has control bit 7 clear, the vector is taken as follows. Source 8 uses the watchdog vector register at byte 0x42. Source 12 uses the register at 0x44, and source 13 uses the register at 0x45. Each of these three registers resets to 0x0F. Any other source gives vector 0x0F.
- R7: The control register of source n sits at byte 0x13+n and reads back what was written. From source 1 to 13, the reset values are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00.
- R8: The mask is writable at bytes 0x36 and 0x37. The pending image uses the same bit layout and reads at bytes 0x3A and 0x3B. Writes to the pending bytes are ignored.
- R9: Pending captures the source levels on every clock edge. The level and vector outputs follow the registers one clock later, which makes them two clocks behind a source change.
- R10: Reads of unmapped bytes return 0, and writes to unmapped bytes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 13 | Source request levels; bit n is source n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| irq_level | output | 3 | Requested processor interrupt level |
| irq_vector | output | 8 | Vector number for the request |

## Verification
All 8192 source patterns are swept under four control programmings, and each result is checked against an arithmetic model.
- The reset programming exercises the reset codes, including sources whose code is suppressed.
- A programming with distinct codes and mixed autovector bits separates selection by code from selection by source number.
- A programming with every code equal shows that ties go to the lowest-numbered source.
- A programming with every code at 3 shows that sub-threshold winners stay silent.

A sweep of all 32 code values on one source pins down the threshold of 4. Single-step checks count the one-cycle and two-cycle output latency. Writes to the pending bytes and to unmapped bytes are checked to have no effect.

// File: rtl/intc_pkg.sv
// Package: shared constants and reset-value computation for the interrupt
// controller. Assumes a byte-wide register space of 256 locations.
package intc_pkg;
    localparam int CTRL_W      = 8;
    localparam int CODE_W      = 5;
    localparam int LVL_W       = 3;
    localparam int VEC_W       = 8;
    localparam int CTRL_BASE   = 'h14;
    localparam int MASK_HI     = 'h36;
    localparam int MASK_LO     = 'h37;
    localparam int PEND_HI     = 'h3A;
    localparam int PEND_LO     = 'h3B;
    localparam int WDOG_VEC_AD = 'h42;
    localparam int VEC_A_AD    = 'h44;
    localparam int VEC_B_AD    = 'h45;
    localparam int AUTO_BASE   = 24;
    localparam int MIN_CODE    = 4;
    localparam int AUTO_BIT    = 7;
    localparam logic [VEC_W-1:0] DFLT_VEC = 8'h0F;

    // Reset value of the control register of source n (computed, not tabulated).
    function automatic logic [CTRL_W-1:0] ctrl_reset(input int n);
        if (n >= 1 && n <= 8)
            return CTRL_W'(((n > 7) ? 7 : n) * 4);
        else if (n >= 9 && n <= 11)
            return 8'h80;
        else
            return 8'h00;
    endfunction
endpackage

// File: rtl/intc_regs.sv
// Register file: pending capture, mask, per-source control registers and
// the three programmable vector registers, with a byte-wide access port.
// Assumes NUM_SRC <= 15 so the mask/pending image fits in 16 bits.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     src_lvl,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_W-1:0]    wdata,
    output logic [CTRL_W-1:0]    rdata,
    output logic [NUM_SRC:1]     pend,
    output logic [NUM_SRC:1]     mask,
    output logic [CTRL_W-1:0]    ctrl [1:NUM_SRC],
    output logic [VEC_W-1:0]     wdog_vec,
    output logic [VEC_W-1:0]     vec_a,
    output logic [VEC_W-1:0]     vec_b
);
    localparam int IMG_W = 16;

    int            addr_i;
    logic [IMG_W-1:0] mask_img;
    logic [IMG_W-1:0] pend_img;

    assign addr_i = int'(addr);

    // Pending bits follow the source levels every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= src_lvl;
    end

    // Mask bits: upper byte at MASK_HI, lower byte at MASK_LO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (wr_en) begin
            for (int b = 1; b <= NUM_SRC; b++) begin
                if (b >= 8 && addr_i == MASK_HI) mask[b] <= wdata[b-8];
                if (b < 8  && addr_i == MASK_LO) mask[b] <= wdata[b];
            end
        end
    end

    // Per-source control registers at CTRL_BASE + n - 1.
    always_ff @(posedge clk) begin
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (!rst_n)
                ctrl[n] <= ctrl_reset(n);
            else if (wr_en && addr_i == CTRL_BASE + n - 1)
                ctrl[n] <= wdata;
        end
    end

    // Programmable vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdog_vec <= DFLT_VEC;
            vec_a    <= DFLT_VEC;
            vec_b    <= DFLT_VEC;
        end else if (wr_en) begin
            if (addr_i == WDOG_VEC_AD) wdog_vec <= wdata;
            if (addr_i == VEC_A_AD)    vec_a    <= wdata;
            if (addr_i == VEC_B_AD)    vec_b    <= wdata;
        end
    end

    // 16-bit images of mask and pending, source n at bit n.
    always_comb begin
        mask_img = '0;
        pend_img = '0;
        for (int b = 1; b <= NUM_SRC; b++) begin
            mask_img[b] = mask[b];
            pend_img[b] = pend[b];
        end
    end

    // Combinational read mux; unmapped bytes read as zero.
    always_comb begin
        rdata = '0;
        if (addr_i >= CTRL_BASE && addr_i < CTRL_BASE + NUM_SRC)
            rdata = ctrl[addr_i - CTRL_BASE + 1];
        else begin
            case (addr_i)
                MASK_HI:     rdata = mask_img[15:8];
                MASK_LO:     rdata = mask_img[7:0];
                PEND_HI:     rdata = pend_img[15:8];
                PEND_LO:     rdata = pend_img[7:0];
                WDOG_VEC_AD: rdata = wdog_vec;
                VEC_A_AD:    rdata = vec_a;
                VEC_B_AD:    rdata = vec_b;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Arbiter: picks the active source with the strictly largest priority code;
// ties keep the lower-numbered source. Flags a win only at or above MIN_CODE.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]   active,
    input  logic [CTRL_W-1:0]  ctrl [1:NUM_SRC],
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);
    logic [CODE_W-1:0] best_code;

    // Linear scan in ascending source order; only a larger code replaces.
    always_comb begin
        best_code = '0;
        win_idx   = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (active[n] && ctrl[n][CODE_W-1:0] > best_code) begin
                best_code = ctrl[n][CODE_W-1:0];
                win_idx   = IDX_W'(n);
            end
        end
        win_valid = (int'(best_code) >= MIN_CODE);
    end
endmodule

// File: rtl/intc_vecout.sv
// Output stage: forms level and vector for the winner and registers them.
// Assumes win_ctrl is the winner's control register when win_valid is high.
module intc_vecout
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 13,
    parameter int IDX_W    = $clog2(NUM_SRC + 1),
    parameter int WDOG_SRC = 8,
    parameter int VEC_A_SRC = 12,
    parameter int VEC_B_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [CTRL_W-1:0]  win_ctrl,
    input  logic [VEC_W-1:0]   wdog_vec,
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    output logic [LVL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]   irq_vector
);
    logic [LVL_W-1:0] lvl_nxt;
    logic [VEC_W-1:0] vec_nxt;
    logic [VEC_W-1:0] table_vec;

    // Explicit vector source for a non-autovectored winner.
    always_comb begin
        if (int'(win_idx) == WDOG_SRC)       table_vec = wdog_vec;
        else if (int'(win_idx) == VEC_A_SRC) table_vec = vec_a;
        else if (int'(win_idx) == VEC_B_SRC) table_vec = vec_b;
        else                                 table_vec = DFLT_VEC;
    end

    // Next level/vector: zero when nothing qualifies.
    always_comb begin
        lvl_nxt = '0;
        vec_nxt = '0;
        if (win_valid) begin
            lvl_nxt = win_ctrl[CODE_W-1:CODE_W-LVL_W];
            if (win_ctrl[AUTO_BIT]) vec_nxt = VEC_W'(AUTO_BASE) + VEC_W'(lvl_nxt);
            else                    vec_nxt = table_vec;
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            irq_level  <= lvl_nxt;
            irq_vector <= vec_nxt;
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
// Top: prioritized vectoring interrupt controller. Registers feed a
// combinational arbiter whose result is registered at the outputs.
// Assumes synchronous active-low reset and NUM_SRC <= 15.
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int ADDR_W    = 8,
    parameter int WDOG_SRC  = 8,
    parameter int VEC_A_SRC = 12,
    parameter int VEC_B_SRC = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC:1]    src_lvl,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic [2:0]          irq_level,
    output logic [7:0]          irq_vector
);
    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1]   pend;
    logic [NUM_SRC:1]   mask;
    logic [NUM_SRC:1]   active;
    logic [CTRL_W-1:0]  ctrl [1:NUM_SRC];
    logic [VEC_W-1:0]   wdog_vec;
    logic [VEC_W-1:0]   vec_a;
    logic [VEC_W-1:0]   vec_b;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [CTRL_W-1:0]  win_ctrl;

    intc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pend(pend), .mask(mask), .ctrl(ctrl),
        .wdog_vec(wdog_vec), .vec_a(vec_a), .vec_b(vec_b)
    );

    // Unmasked pending sources.
    assign active = pend & ~mask;

    intc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .active(active), .ctrl(ctrl),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    // Winner's control register, zero when no winner.
    always_comb begin
        win_ctrl = '0;
        for (int n = 1; n <= NUM_SRC; n++)
            if (int'(win_idx) == n) win_ctrl = ctrl[n];
    end

    intc_vecout #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .WDOG_SRC(WDOG_SRC),
        .VEC_A_SRC(VEC_A_SRC), .VEC_B_SRC(VEC_B_SRC)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
        .win_ctrl(win_ctrl), .wdog_vec(wdog_vec), .vec_a(vec_a), .vec_b(vec_b),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );
endmodule

// File: rtl/intc_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
module intc_chk #(
    parameter int NUM_SRC = 13,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC:1]   src_lvl,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SRC:1]   pend,
    input logic [NUM_SRC:1]   mask,
    input logic               win_valid,
    input logic [7:0]         win_ctrl,
    input logic [2:0]         irq_level,
    input logic [7:0]         irq_vector
);
    logic past_ok;

    // Marks that at least one post-reset edge has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3
    quiet_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == 3'd0 |-> irq_vector == 8'd0);

    // R1
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past((pend & ~mask) == '0) |-> irq_level == 3'd0);

    // R9
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> pend == $past(src_lvl));

    // R5
    autovec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(win_valid && win_ctrl[7]) |-> irq_vector == 8'd24 + 8'(irq_level));

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr != ADDR_W'('h36) && addr != ADDR_W'('h37) |=> $stable(mask));
endmodule

bind prio_vec_intc intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en), .addr(addr),
    .pend(pend), .mask(mask), .win_valid(win_valid), .win_ctrl(win_ctrl),
    .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] src_lvl = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // Bench-side shadow of programmed state.
    logic [7:0]  ctrl_m [1:13];
    logic [13:1] mask_m;
    logic [7:0]  wd_m, va_m, vb_m;

    prio_vec_intc uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 180000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<180000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int rst_ctrl(input int n);
        if (n <= 7) return n * 4;
        if (n == 8) return 'h1C;
        if (n <= 11) return 'h80;
        return 0;
    endfunction

    // Expected {level, vector} from the requirements.
    function automatic int model(input logic [13:1] s);
        int best = 0, idx = 0, lvl, vec;
        for (int i = 1; i <= 13; i++)
            if (s[i] && !mask_m[i] && int'(ctrl_m[i][4:0]) > best) begin
                best = int'(ctrl_m[i][4:0]); idx = i;
            end
        if (best < 4) return 0;
        lvl = best / 4;
        if (ctrl_m[idx][7]) vec = 24 + lvl;
        else if (idx == 8) vec = wd_m;
        else if (idx == 12) vec = va_m;
        else if (idx == 13) vec = vb_m;
        else vec = 'h0F;
        return lvl * 256 + vec;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 8'(a);
        #1 d = int'(rdata);
    endtask

    task automatic set_ctrl(input int n, input int v);
        wr('h13 + n, v);
        ctrl_m[n] = 8'(v);
    endtask

    task automatic set_mask(input int m);
        wr('h36, m >> 8);
        wr('h37, m & 'hFF);
        mask_m = 13'(m >> 1);
    endtask

    // Sweep every source pattern and compare both outputs with the model.
    task automatic sweep(input string req);
        for (int p = 0; p < 8192; p++) begin
            @(negedge clk);
            src_lvl = 13'(p);
            @(negedge clk);
            @(negedge clk);
            chk(req, int'(irq_level) * 256 + int'(irq_vector), model(13'(p)));
        end
    endtask

    initial begin
        int d;
        for (int n = 1; n <= 13; n++) ctrl_m[n] = 8'(rst_ctrl(n));
        mask_m = '1; wd_m = 8'h0F; va_m = 8'h0F; vb_m = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset control values and offsets
        for (int n = 1; n <= 13; n++) begin
            rd('h13 + n, d); chk("R7 ctrl reset", d, rst_ctrl(n));
        end
        // R1 mask reset image
        rd('h36, d); chk("R1 mask hi reset", d, 'h3F);
        rd('h37, d); chk("R1 mask lo reset", d, 'hFE);
        // R6 vector registers reset
        rd('h42, d); chk("R6 wdog vec reset", d, 'h0F);
        rd('h44, d); chk("R6 vec12 reset", d, 'h0F);
        rd('h45, d); chk("R6 vec13 reset", d, 'h0F);
        chk("R3 outputs at reset", int'(irq_level) + int'(irq_vector), 0);

        // R1 all sources asserted but masked
        @(negedge clk); src_lvl = '1;
        repeat (3) @(negedge clk);
        chk("R1 masked outputs", int'(irq_level) * 256 + int'(irq_vector), 0);
        // R8 pending image
        rd('h3A, d); chk("R8 pend hi", d, 'h3F);
        rd('h3B, d); chk("R8 pend lo", d, 'hFE);
        wr('h3B, 'h00);
        rd('h3B, d); chk("R8 pend write ignored", d, 'hFE);

        // R10 unmapped address
        rd('h50, d); chk("R10 unmapped read", d, 0);
        wr('h50, 'hFF);
        rd('h37, d); chk("R10 unmapped write mask", d, 'hFE);
        chk("R10 unmapped write output", int'(irq_level), 0);

        // R1 R2 R4 R6 sweep with reset programming, unmasked
        set_mask(0);
        rd('h37, d); chk("R8 mask write", d, 0);
        sweep("R2 R4 R6 reset ctrl sweep");

        // R9 latency from source and from register write
        @(negedge clk); src_lvl = '0;
        repeat (3) @(negedge clk);
        src_lvl = 13'b0000001000000;  // source 7
        @(negedge clk);
        chk("R9 one edge after source", int'(irq_level), 0);
        @(negedge clk);
        chk("R9 two edges after source", int'(irq_level), 7);
        wr('h13 + 7, 'h9C);
        chk("R9 one edge after write", int'(irq_vector), 'h0F);
        @(negedge clk);
        chk("R9 two edges after write", int'(irq_vector), 31);
        ctrl_m[7] = 8'h9C;

        // R2 R5 R6 distinct codes, mixed autovector, custom vectors
        wr('h42, 'hA5); wd_m = 8'hA5;
        wr('h44, 'h5A); va_m = 8'h5A;
        wr('h45, 'h3C); vb_m = 8'h3C;
        for (int n = 1; n <= 13; n++)
            set_ctrl(n, ((n * 7) % 32) | ((n % 3 == 0) ? 'h80 : 0));
        sweep("R2 R5 R6 distinct code sweep");

        // R2 ties: all codes equal, lowest index wins
        for (int n = 1; n <= 13; n++) set_ctrl(n, 'h10 | ((n % 2 == 1) ? 'h80 : 0));
        sweep("R2 tie sweep");

        // R3 every code below threshold
        for (int n = 1; n <= 13; n++) set_ctrl(n, 3);
        sweep("R3 below-threshold sweep");

        // R3 R4 code sweep on a single source
        @(negedge clk); src_lvl = 13'b0000000010000;  // source 5
        for (int f = 0; f < 32; f++) begin
            set_ctrl(5, f);
            @(negedge clk);
            chk("R3 R4 single code sweep", int'(irq_level) * 256 + int'(irq_vector),
                (f < 4) ? 0 : (f / 4) * 256 + 'h0F);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule